// File: doc/BRIEF.md
# ATA PIO Read Interrupt Pacer

This block serves programmed-I/O reads of a hard disk's data port. A read command sets a starting LBA, a sector count and a pacing block size. The block fetches the first 512-byte sector into a local buffer. It then returns one 16-bit word per host read, taken from the buffer at the current offset. The transfer index counts 16-bit words, so one word is two bytes and a sector is 256 words. Word k of a sector holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8, which is little-endian order.

When a read lands on a sector boundary after the first sector, the block first increments the LBA. It then fetches that sector from a request/valid sector source, and only afterwards returns the word. An interrupt fires after each completed block of sectors and also on the last word of the transfer. Each interrupt updates the data-request flag and the three interrupt-reason flags.

Plain sector reads pace per sector. Multiple-mode reads pace per configured block. A sector count of 0 stands for 2^CNT_W sectors. The block accepts a new command only while it is idle.

Top module: `pio_read_pacer`

## Requirements
- R1: After reset: sts_busy=0, sts_drq=0, sts_ready=1, irq=0, rd_valid=0, ovr_err=0, rsn_io=0, rsn_cd=0, rsn_rel=0. The configured multiple count is 1.
- R2: A command with cmd_op 0x20, 0x21 or 0x24 uses a block size of 1 sector. A command with cmd_op 0xC4 uses the configured multiple count. mult_set loads that count from mult_val, and a value of 0 is taken as 1. Any other cmd_op is ignored and causes no src_req. An accepted command pulses src_req with src_lba equal to cmd_lba in the cycle after it is taken. sts_busy stays 1 until 256 src_valid words have arrived. After that, sts_busy=0 and sts_drq=1, and no irq is raised.
- R3: A served read sets rd_valid one cycle after rd_req. rd_data is then the buffer word at the index offset (index mod 256), and the index advances by one word.
- R4: An rd_req while the index is at or beyond the transfer length pulses ovr_err. It gives no rd_valid and no irq.
- R5: An rd_req at offset 0 with a non-zero index starts a fetch: src_req pulses with src_lba equal to the previous LBA plus 1, and sts_busy=1. The word at offset 0 of the new sector is returned one cycle after the fetch completes.
- R6: An interrupt event occurs when the advanced index is a multiple of 256 x block size, or when it equals the transfer length. At no other time is irq raised.
- R7: At an intermediate event (index below the length), sts_drq=1 and rsn_cd=0.
- R8: At the final event, sts_drq=0, rsn_cd=1 and rsn_rel=0.
- R9: At every event, irq pulses for exactly one cycle, with sts_ready=1, sts_busy=0 and rsn_io=1 (device to host).
- R10: While a sector fetch is in progress, rd_req and cmd_valid are ignored: no rd_valid, no ovr_err, and no change of LBA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_lba | input | LBA_W | Starting LBA |
| cmd_count | input | CNT_W | Sector count (0 = 2^CNT_W) |
| mult_set | input | 1 | Load the multiple-mode count |
| mult_val | input | CNT_W | Multiple-mode count (0 = 1) |
| rd_req | input | 1 | Host 16-bit data-port read |
| rd_valid | output | 1 | rd_data holds a returned word |
| rd_data | output | 16 | Returned word, little-endian |
| ovr_err | output | 1 | Overrun pulse |
| src_req | output | 1 | Sector fetch request pulse |
| src_lba | output | LBA_W | LBA of the requested sector |
| src_valid | input | 1 | Sector word strobe |
| src_word | input | 16 | Sector word, in ascending order |
| sts_busy | output | 1 | Status busy |
| sts_drq | output | 1 | Status data request |
| sts_ready | output | 1 | Status ready |
| rsn_io | output | 1 | Reason: I/O direction |
| rsn_cd | output | 1 | Reason: command/data |
| rsn_rel | output | 1 | Reason: release |
| irq | output | 1 | Interrupt pulse |

## Verification
Two events can fall on the same word. A block boundary can coincide with the last word of the transfer, as when a single-sector read ends on a sector edge or a 2-sector block ends a 4-sector read; the final reason bits must then win over the intermediate ones. A 3-sector multiple-mode read with a block of 2 provokes the other case, where the final event lands off a block boundary. At every word the bench judges irq and the reason flags against values it derives from the index, the length and the block size. A host read and a new command are also raised during a sector fetch, and the bench confirms that both leave no trace in the returned data or the LBA.

// File: rtl/pio_pacer_pkg.sv
// Shared types and opcode decoding for the PIO read pacer.
// Assumes 8-bit opcodes; only read opcodes are recognised.
package pio_pacer_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SERVE} pacer_state_e;

    localparam logic [7:0] OP_RD_RETRY  = 8'h20;
    localparam logic [7:0] OP_RD_NORTRY = 8'h21;
    localparam logic [7:0] OP_RD_EXT    = 8'h24;
    localparam logic [7:0] OP_RD_MULT   = 8'hC4;

    // True for opcodes that pace one sector at a time
    function automatic logic op_is_single(input logic [7:0] op);
        return (op == OP_RD_RETRY) || (op == OP_RD_NORTRY) || (op == OP_RD_EXT);
    endfunction
endpackage

// File: rtl/pacer_sector_buf.sv
// One-sector word buffer: a write port for the fill and a registered read port.
// Assumes writes and reads never target the same cycle (fill and serve are exclusive).
module pacer_sector_buf #(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data
);
    logic [15:0] mem [WORDS];

    // Store incoming sector words
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the addressed word on a host read
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pacer_event_eval.sv
// Decides from the advanced index whether a read completes a sector, a block
// or the whole transfer. Purely combinational; assumes blk is non-zero.
module pacer_event_eval #(
    parameter int AW = 8,
    parameter int XW = 17,
    parameter int BW = 9
) (
    input  logic [XW-1:0] idx_next,
    input  logic [XW-1:0] len,
    input  logic [BW-1:0] blk_cnt,
    input  logic [BW-1:0] blk,
    output logic          sect_end,
    output logic          blk_end,
    output logic          last_word,
    output logic          event_hit
);
    // Boundary and event decode
    always_comb begin
        sect_end  = (idx_next[AW-1:0] == '0);
        blk_end   = sect_end && ((blk_cnt + BW'(1)) == blk);
        last_word = (idx_next == len);
        event_hit = blk_end || last_word;
    end
endmodule

// File: rtl/pio_read_pacer.sv
// PIO read pacer: serves 16-bit data-port reads from a sector buffer, refills
// it at sector edges from a request/valid source and paces interrupts per block.
// Assumes the source returns exactly WORDS words per request, in order.
module pio_read_pacer
    import pio_pacer_pkg::*;
#(
    parameter int SECT_WORDS = 256,
    parameter int LBA_W      = 28,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [LBA_W-1:0] cmd_lba,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             mult_set,
    input  logic [CNT_W-1:0] mult_val,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic             ovr_err,
    output logic             src_req,
    output logic [LBA_W-1:0] src_lba,
    input  logic             src_valid,
    input  logic [15:0]      src_word,
    output logic             sts_busy,
    output logic             sts_drq,
    output logic             sts_ready,
    output logic             rsn_io,
    output logic             rsn_cd,
    output logic             rsn_rel,
    output logic             irq
);
    localparam int AW = $clog2(SECT_WORDS);
    localparam int BW = CNT_W + 1;
    localparam int XW = AW + CNT_W + 1;

    pacer_state_e   state;
    logic [XW-1:0]  idx, len;
    logic [BW-1:0]  blk, blk_cnt, mult_cfg;
    logic [AW-1:0]  fill_cnt;
    logic           pending;

    logic cmd_take, op_known, overrun, need_fetch, do_serve, fill_done;
    logic sect_end, blk_end, last_word, event_hit;
    logic [BW-1:0] sect_n;

    // Request decode for the current cycle
    always_comb begin
        op_known   = op_is_single(cmd_op) || (cmd_op == OP_RD_MULT);
        cmd_take   = (state == ST_IDLE) && cmd_valid && op_known;
        overrun    = (state == ST_IDLE) && rd_req && !cmd_take && (idx >= len);
        need_fetch = (idx[AW-1:0] == '0) && (idx != '0);
        do_serve   = (state == ST_SERVE) ||
                     ((state == ST_IDLE) && rd_req && !cmd_take && !overrun && !need_fetch);
        fill_done  = (state == ST_FILL) && src_valid && (fill_cnt == AW'(SECT_WORDS - 1));
        sect_n     = (cmd_count == '0) ? BW'(1) << CNT_W : {1'b0, cmd_count};
    end

    pacer_sector_buf #(.WORDS(SECT_WORDS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   ((state == ST_FILL) && src_valid),
        .wr_addr (fill_cnt),
        .wr_data (src_word),
        .rd_en   (do_serve),
        .rd_addr (idx[AW-1:0]),
        .rd_data (rd_data)
    );

    pacer_event_eval #(.AW(AW), .XW(XW), .BW(BW)) u_eval (
        .idx_next  (idx + XW'(1)),
        .len       (len),
        .blk_cnt   (blk_cnt),
        .blk       (blk),
        .sect_end  (sect_end),
        .blk_end   (blk_end),
        .last_word (last_word),
        .event_hit (event_hit)
    );

    // Command, fill, serve and interrupt sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  idx <= '0;  len <= '0;
            blk <= BW'(1);  blk_cnt <= '0;  mult_cfg <= BW'(1);
            fill_cnt <= '0;  pending <= 1'b0;  src_lba <= '0;
            src_req <= 1'b0;  rd_valid <= 1'b0;  ovr_err <= 1'b0;  irq <= 1'b0;
            sts_busy <= 1'b0;  sts_drq <= 1'b0;  sts_ready <= 1'b1;
            rsn_io <= 1'b0;  rsn_cd <= 1'b0;  rsn_rel <= 1'b0;
        end else begin
            src_req  <= 1'b0;
            ovr_err  <= 1'b0;
            irq      <= 1'b0;
            rd_valid <= do_serve;
            if (mult_set) mult_cfg <= (mult_val == '0) ? BW'(1) : {1'b0, mult_val};
            case (state)
                ST_IDLE: begin
                    if (cmd_take) begin
                        state    <= ST_FILL;
                        idx      <= '0;
                        len      <= XW'(sect_n) << AW;
                        blk      <= op_is_single(cmd_op) ? BW'(1) : mult_cfg;
                        blk_cnt  <= '0;
                        src_lba  <= cmd_lba;
                        src_req  <= 1'b1;
                        fill_cnt <= '0;
                        pending  <= 1'b0;
                        sts_busy <= 1'b1;
                        sts_drq  <= 1'b0;
                    end else if (overrun) begin
                        ovr_err <= 1'b1;
                    end else if (rd_req && need_fetch) begin
                        state    <= ST_FILL;
                        src_lba  <= src_lba + LBA_W'(1);
                        src_req  <= 1'b1;
                        fill_cnt <= '0;
                        pending  <= 1'b1;
                        sts_busy <= 1'b1;
                    end
                end
                ST_FILL: begin
                    if (src_valid) fill_cnt <= fill_cnt + AW'(1);
                    if (fill_done) begin
                        sts_busy <= 1'b0;
                        if (pending) begin
                            state <= ST_SERVE;
                        end else begin
                            state   <= ST_IDLE;
                            sts_drq <= 1'b1;
                        end
                    end
                end
                ST_SERVE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
            if (do_serve) begin
                idx <= idx + XW'(1);
                if (sect_end) blk_cnt <= blk_end ? '0 : blk_cnt + BW'(1);
                if (event_hit) begin
                    irq       <= 1'b1;
                    sts_ready <= 1'b1;
                    sts_busy  <= 1'b0;
                    rsn_io    <= 1'b1;
                    if (last_word) begin
                        sts_drq <= 1'b0;
                        rsn_cd  <= 1'b1;
                        rsn_rel <= 1'b0;
                    end else begin
                        sts_drq <= 1'b1;
                        rsn_cd  <= 1'b0;
                    end
                end
            end
        end
    end

    // R9: every interrupt carries ready, not busy, device-to-host direction
    a_r9_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_ready && !sts_busy && rsn_io));
    // R8: a final interrupt reports command/data and no release
    a_r8_final_reason: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !sts_drq) |-> (rsn_cd && !rsn_rel));
    // R7: an intermediate interrupt reports data phase
    a_r7_mid_reason: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && sts_drq) |-> !rsn_cd);
    // R4: an overrun returns no data and no interrupt
    a_r4_overrun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |-> (!rd_valid && !irq));
    // R10: busy is shown for the whole fill
    a_r10_busy_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> sts_busy);
    // R5: a mid-transfer fetch targets the following LBA
    a_r5_next_lba: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && pending) |-> (src_lba == $past(src_lba) + LBA_W'(1)));
    // R3: each returned word advances the index by one
    a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (idx == $past(idx) + XW'(1)));
endmodule

// File: tb/pio_read_pacer_tb.sv
`timescale 1ns/1ps
module pio_read_pacer_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, mult_set = 0, rd_req = 0, src_valid = 0;
    logic [7:0] cmd_op = 0, cmd_count = 0, mult_val = 0;
    logic [27:0] cmd_lba = 0;
    logic [15:0] src_word = 0;
    logic rd_valid, ovr_err, src_req, sts_busy, sts_drq, sts_ready;
    logic rsn_io, rsn_cd, rsn_rel, irq;
    logic [15:0] rd_data;
    logic [27:0] src_lba;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    pio_read_pacer u_dut (.*);

    // Sector source model: word k of a sector holds {lba[7:0], k[7:0]}
    always begin
        @(negedge clk);
        if (src_req) begin
            logic [27:0] l;
            l = src_lba;
            repeat (2) @(negedge clk);
            for (int k = 0; k < 256; k++) begin
                src_valid = 1'b1;
                src_word  = {l[7:0], 8'(k)};
                @(negedge clk);
            end
            src_valid = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [7:0] op, input logic [27:0] lba, input logic [7:0] cnt);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_lba = lba; cmd_count = cnt;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic set_mult(input logic [7:0] v);
        @(negedge clk); mult_set = 1; mult_val = v;
        @(negedge clk); mult_set = 0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 400 && sts_busy; n++) @(negedge clk);
    endtask

    task automatic read_expect(input logic [15:0] exp_d, input bit exp_irq, input bit exp_fin);
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
        for (int n = 0; n < 400 && !rd_valid && !ovr_err; n++) @(negedge clk);
        chk(rd_valid && rd_data == exp_d, "R3", "read word", rd_data, exp_d);
        chk(irq == exp_irq, "R6", "irq at event", irq, exp_irq);
        if (exp_irq) begin
            chk(sts_ready && !sts_busy && rsn_io, "R9", "ready/busy/io",
                {sts_ready, sts_busy, rsn_io}, 3'b101);
            if (exp_fin)
                chk(!sts_drq && rsn_cd && !rsn_rel, "R8", "final drq/cd/rel",
                    {sts_drq, rsn_cd, rsn_rel}, 3'b010);
            else
                chk(sts_drq && !rsn_cd, "R7", "intermediate drq/cd", {sts_drq, rsn_cd}, 2'b10);
        end
    endtask

    task automatic expect_overrun();
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
        chk(ovr_err && !rd_valid && !irq, "R4", "overrun pulse", {ovr_err, rd_valid, irq}, 3'b100);
    endtask

    // Full transfer: command, first fill, every word, events, then overrun
    task automatic run_xfer(input logic [7:0] op, input logic [27:0] lba,
                            input int nsec, input int blk);
        int len = nsec * 256;
        issue_cmd(op, lba, 8'(nsec));
        chk(src_req && src_lba == lba && sts_busy, "R2", "first fetch", src_lba, lba);
        wait_idle();
        chk(!sts_busy && sts_drq && !irq, "R2", "first sector ready", {sts_busy, sts_drq, irq}, 3'b010);
        for (int i = 0; i < len; i++) begin
            int nx = i + 1;
            logic [27:0] l = lba + 28'(i / 256);
            read_expect({l[7:0], 8'(i % 256)}, (nx % (256 * blk) == 0) || (nx == len), nx == len);
        end
        @(negedge clk);
        chk(!irq, "R9", "irq one cycle", irq, 0);
        expect_overrun();
    endtask

    // Fetch at a sector edge while a read and a command arrive mid-fill
    task automatic fill_ignore();
        issue_cmd(8'h21, 28'h40, 8'd2);
        wait_idle();
        for (int i = 0; i < 256; i++) read_expect({8'h40, 8'(i)}, i == 255, 1'b0);
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
        chk(src_req && src_lba == 28'h41 && sts_busy && !rd_valid, "R5", "edge fetch",
            src_lba, 28'h41);
        @(negedge clk); rd_req = 1; cmd_valid = 1; cmd_op = 8'h20; cmd_lba = 28'h99; cmd_count = 1;
        @(negedge clk); rd_req = 0; cmd_valid = 0;
        chk(!rd_valid && !ovr_err, "R10", "read during fill", {rd_valid, ovr_err}, 0);
        for (int n = 0; n < 400 && !rd_valid; n++) @(negedge clk);
        chk(rd_valid && rd_data == 16'h4100, "R5", "word after fetch", rd_data, 16'h4100);
        @(negedge clk);
        chk(!rd_valid && src_lba == 28'h41, "R10", "no extra word, lba kept", src_lba, 28'h41);
        for (int i = 1; i < 256; i++) read_expect({8'h41, 8'(i)}, i == 255, i == 255);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!sts_busy && !sts_drq && sts_ready && !irq && !rd_valid && !ovr_err,
            "R1", "reset status", {sts_busy, sts_drq, sts_ready, irq}, 4'b0010);
        chk(!rsn_io && !rsn_cd && !rsn_rel, "R1", "reset reasons", {rsn_io, rsn_cd, rsn_rel}, 0);
        rst_n = 1;
        expect_overrun();
        issue_cmd(8'h30, 28'h5, 8'd1);
        chk(!src_req && !sts_busy, "R2", "unknown opcode ignored", src_req, 0);
        run_xfer(8'h20, 28'h10, 2, 1);
        run_xfer(8'h24, 28'h20, 1, 1);
        set_mult(8'd2);
        run_xfer(8'hC4, 28'h30, 3, 2);
        run_xfer(8'hC4, 28'h50, 4, 2);
        set_mult(8'd0);
        run_xfer(8'hC4, 28'h60, 2, 1);
        fill_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule